// File: doc/BRIEF.md
# Per-channel receive code substitution

This block sits on the serial receive data path of a 24-channel, 193-bit-per-frame T1 stream. It runs one bit per clock. One framing bit starts each frame, and 24 eight-bit channel slots follow it. For every channel whose bit is set in a 24-bit mask, the block replaces the slot's sample on the output with a substitute byte. The substitute is either a constant idle byte or one byte of a repeating eight-byte digital milliwatt tone. A single select input picks between the two for all marked channels.

A frame sync pulse marks the framing bit. After the first pulse the block keeps frame position on its own, and it realigns whenever another pulse arrives. Each channel keeps its own position in the tone sequence, so a channel that is marked for tone plays the sequence at one byte per frame. Mask and select are taken only at the first bit of a slot, so a byte is never mixed from two settings. The output is registered.

Top module: `rx_chan_subst`

## Requirements
- R1: Mask bit n (n = 0..23) controls channel n+1. Counting the framing bit as position 0, channel n+1 occupies positions 8n+1 to 8n+8 of the frame. Bit 0 of the mask therefore controls positions 1..8, and bit 23 controls positions 185..192.
- R2: In a slot whose mask bit is 0, the input bits pass to the output unchanged.
- R3: In a marked slot with `tone_sel` = 0, the output carries the byte 0x7F, most significant bit first.
- R4: In a marked slot with `tone_sel` = 1, the output carries one byte of the sequence 1E, 0B, 0B, 1E, 9E, 8B, 8B, 9E, most significant bit first. Each channel starts at 1E after reset. A channel moves to the next entry, wrapping after the eighth, only when it completes a slot that carried a tone byte.
- R5: The framing bit (the sync cycle, and every 193rd bit after it) always passes unchanged.
- R6: Mask and select are sampled at the first bit of each slot. A change during a slot has no effect until the next slot.
- R7: Until the first frame sync after reset, every bit passes unchanged.
- R8: A frame sync at any bit makes that bit the framing bit, and any partial slot is abandoned. Without a sync the block repeats the 193-bit frame on its own.
- R9: `dout` follows the bit presented at a clock edge, with one register of latency. It is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High on the framing bit |
| din | input | 1 | Serial receive data |
| chan_mask | input | 24 | One substitution enable per channel, bit 0 = channel 1 |
| tone_sel | input | 1 | 0 = idle byte, 1 = milliwatt sequence |
| dout | output | 1 | Serial data after substitution |

## Verification
Every output bit is due one rising edge after the bit is presented: the value sampled at edge k appears on `dout` just after edge k. The bench changes its inputs at the falling edge and compares `dout` 2 ns after the next rising edge. It computes the expected value with its own model of frame position, per-channel tone index and slot-start sampling. Random mask and select changes within slots test R6 against that same model. In the model these changes take effect only when a slot's first bit is presented.

// File: rtl/rx_chan_subst.sv
`timescale 1ns/1ps
module rx_chan_subst #(
  parameter int NCH = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_sync,
  input  logic           din,
  input  logic [NCH-1:0] chan_mask,
  input  logic           tone_sel,
  output logic           dout
);
  localparam int BPC = 8;
  localparam int CW  = $clog2(NCH);
  localparam int BW  = $clog2(BPC);
  localparam logic [BPC-1:0] IDLE_BYTE = 8'h7F;
  localparam logic [BW-1:0]  BLAST     = BW'(BPC-1);
  localparam logic [CW-1:0]  CLAST     = CW'(NCH-1);

  function automatic logic [BPC-1:0] tone_byte(input logic [2:0] i);
    case (i)
      3'd0, 3'd3: tone_byte = 8'h1E;
      3'd1, 3'd2: tone_byte = 8'h0B;
      3'd4, 3'd7: tone_byte = 8'h9E;
      default:    tone_byte = 8'h8B;
    endcase
  endfunction

  logic           locked_q, fnext_q, act_q, tone_q;
  logic [CW-1:0]  ch_q;
  logic [BW-1:0]  bt_q;
  logic [BPC-1:0] code_q;
  logic [2:0]     idx_q [NCH];

  wire fbit  = frame_sync | fnext_q;
  wire lockd = locked_q | frame_sync;
  wire first = ~fbit & (bt_q == '0);
  wire act   = first ? chan_mask[ch_q] : act_q;
  wire tone  = first ? tone_sel : tone_q;
  wire [BPC-1:0] code = first ? (tone_sel ? tone_byte(idx_q[ch_q]) : IDLE_BYTE) : code_q;
  wire sub   = lockd & ~fbit & act;
  wire last  = ~fbit & (bt_q == BLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      fnext_q  <= 1'b0;
      act_q    <= 1'b0;
      tone_q   <= 1'b0;
      code_q   <= '0;
      ch_q     <= '0;
      bt_q     <= '0;
      dout     <= 1'b0;
    end else begin
      dout <= sub ? code[BLAST - bt_q] : din;
      if (fbit) begin
        locked_q <= lockd;
        fnext_q  <= 1'b0;
        ch_q     <= '0;
        bt_q     <= '0;
      end else begin
        act_q  <= act;
        tone_q <= tone;
        code_q <= code;
        if (last) begin
          bt_q <= '0;
          if (ch_q == CLAST) begin
            ch_q    <= '0;
            fnext_q <= 1'b1;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end else begin
          bt_q <= bt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) idx_q[i] <= '0;
    end else if (last && lockd && act && tone) begin
      idx_q[ch_q] <= idx_q[ch_q] + 3'd1;
    end
  end
endmodule

module rx_chan_subst_chk #(
  parameter int NCH = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frame_sync,
  input logic                   din,
  input logic                   dout,
  input logic [$clog2(NCH)-1:0] ch_q,
  input logic [2:0]             bt_q
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else if (frame_sync) seen_q <= 1'b1;

  // R7
  prelock_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !frame_sync) |=> dout == $past(din));
  // R5
  fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> dout == $past(din));
  // R8
  resync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (ch_q == '0 && bt_q == 3'd0));
  // R1
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_q <= ($clog2(NCH))'(NCH-1));
  // R9
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |-> !dout);
endmodule

bind rx_chan_subst rx_chan_subst_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .din(din),
  .dout(dout), .ch_q(ch_q), .bt_q(bt_q)
);

// File: tb/rx_chan_subst_tb.sv
`timescale 1ns/1ps
module rx_chan_subst_tb;
  logic clk = 0, rst_n = 0, frame_sync = 0, din = 0, tone_sel = 0;
  logic [23:0] chan_mask = '0;
  logic dout;

  always #10 clk = ~clk;

  rx_chan_subst u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .din(din),
    .chan_mask(chan_mask), .tone_sel(tone_sel), .dout(dout)
  );

  int checks = 0, errors = 0;
  string tag_ov = "";
  int m_pos = 0;
  bit m_lock = 0, m_act = 0, m_sel = 0;
  logic [7:0] m_code = '0;
  int m_idx [24];

  function automatic logic [7:0] mw_ref(int i);
    case (i % 8)
      0, 3: return 8'h1E;
      1, 2: return 8'h0B;
      4, 7: return 8'h9E;
      default: return 8'h8B;
    endcase
  endfunction

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b (frame pos %0d)", tag, act, exp, m_pos);
    end
  endtask

  task automatic step(input logic d, input logic fs, input bit flip);
    logic exp;
    string tag;
    int ch, b;
    @(negedge clk);
    if (flip) begin
      chan_mask = chan_mask ^ (24'd1 << ($urandom % 24));
      if ($urandom % 4 == 0) tone_sel = ~tone_sel;
    end
    din = d;
    frame_sync = fs;
    if (fs) begin m_pos = 0; m_lock = 1; end
    if (!m_lock) begin
      exp = d; tag = "R7";
    end else if (m_pos == 0) begin
      exp = d; tag = "R5";
    end else begin
      ch = (m_pos - 1) / 8;
      b  = (m_pos - 1) % 8;
      if (b == 0) begin
        m_act  = chan_mask[ch];
        m_sel  = tone_sel;
        m_code = tone_sel ? mw_ref(m_idx[ch]) : 8'h7F;
      end
      exp = m_act ? m_code[7-b] : d;
      tag = !m_act ? "R2" : (m_sel ? "R4" : "R3");
      if (b == 7 && m_act && m_sel) m_idx[ch]++;
    end
    @(posedge clk);
    #2;
    chk(dout, exp, tag_ov != "" ? tag_ov : tag);
    if (m_lock) m_pos = (m_pos == 192) ? 0 : m_pos + 1;
  endtask

  task automatic frames(int n, bit sync, int flip_mod);
    for (int f = 0; f < n; f++)
      for (int p = 0; p < 193; p++)
        step(1'($urandom % 2), sync && p == 0,
             flip_mod > 0 && ($urandom % flip_mod) == 0);
  endtask

  task automatic const_frame(logic d);
    for (int p = 0; p < 193; p++) step(d, p == 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 24; i++) m_idx[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(dout, 1'b0, "R9");
    @(negedge clk);
    rst_n = 1;

    // R7: no sync yet, everything passes even with all channels marked
    chan_mask = '1;
    for (int i = 0; i < 60; i++) step(1'($urandom % 2), 0, 0);

    // R2: nothing marked
    chan_mask = '0;
    frames(2, 1, 0);

    // R3: idle byte on random channels
    chan_mask = 24'($urandom);
    tone_sel = 0;
    frames(3, 1, 0);

    // R4: milliwatt tone, long enough to wrap the sequence
    chan_mask = 24'($urandom);
    tone_sel = 1;
    frames(10, 1, 0);

    // R1: first and last channel ends of the mask
    tag_ov = "R1";
    tone_sel = 0;
    chan_mask = 24'h000001;
    const_frame(1'b0);
    chan_mask = 24'h800000;
    const_frame(1'b1);

    // R6: mask/select changes at random bits within slots
    tag_ov = "R6";
    chan_mask = 24'($urandom);
    frames(6, 1, 5);

    // R8: flywheel with no sync, then a sync mid-frame and flywheel again
    tag_ov = "R8";
    chan_mask = 24'($urandom);
    tone_sel = 1;
    frames(3, 0, 0);
    for (int i = 0; i < 77; i++) step(1'($urandom % 2), 0, 0);
    step(1'($urandom % 2), 1, 0);
    for (int i = 0; i < 2 * 193; i++) step(1'($urandom % 2), 0, 0);
    chan_mask = 24'($urandom);
    tone_sel = 0;
    for (int i = 0; i < 30; i++) step(1'($urandom % 2), 0, 0);
    step(1'($urandom % 2), 1, 0);
    for (int i = 0; i < 193; i++) step(1'($urandom % 2), 0, 0);
    tag_ov = "";

    frames(4, 1, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule